// File: doc/BRIEF.md
# Shared Packet Memory Host Access Arbiter

This block gives a host processor read and write access to the shared packet memory without disturbing packet traffic. The memory consists of two dual-port RAMs working side by side, each of 512 rows by 20 bytes. One RAM holds the master byte stream and the other holds the slave byte stream. A host access names one row (0 to 511) and one of the two RAMs. Packet inputs and outputs always come first. The host is given a memory slot only when packet traffic leaves one free.

The arbiter makes its decisions at the start of each packet cycle, which is marked by `cyc_start`. A waiting host write can take a slot whenever at least one packet input is idle. A waiting host read can take a slot whenever at least one packet output is idle. Some packet-cycle lengths, set in `cfg_len` in bytes, leave spare sequencer slots that the host can use directly. These lengths are 17 to 20 and 34 to 40. The lengths 16 and 32 leave no spare slot. For those two lengths, the `cfg_prio` bit lets the host take a packet slot once it has waited through two packet cycles. This bounds host latency to three packet cycles.

The controller is a four-state machine:
- **IDLE**: no request is held.
- **WAIT**: a request is held and waits for a slot.
- **GRANT**: the memory strobe is driven for one clock.
- **DONE**: completion is reported for one clock.

The transitions are:
- **accept**: IDLE to WAIT, when `cpu_req` is seen.
- **win**: WAIT to GRANT, on a `cyc_start` where a slot is eligible.
- **issue**: GRANT to DONE, always.
- **retire**: DONE to IDLE, always.

A WAIT state that sees `cyc_start` with no eligible slot stays in WAIT. Its wait count then goes up, saturating at 2.

Top module: `sma_host_arbiter`

## Requirements
- R1: While reset is held low, and on the first clock after it is released, `cpu_busy`, `mem_en`, `cpu_done` and `slot_steal` are all 0.
- R2: If `cpu_req` is seen while `cpu_busy` is 0, the request's `cpu_we`, `cpu_row`, `cpu_bank` and `cpu_wdata` are captured and `cpu_busy` is 1 from the next clock. If `cpu_req` is seen while `cpu_busy` is 1, it is ignored and the captured fields do not change.
- R3: A held write (`cpu_we`=1) wins a slot only on a `cyc_start` where some bit of `in_idle` is 1, or where the length gives a spare slot, or where a slot is forced.
- R4: A held read (`cpu_we`=0) wins a slot only on a `cyc_start` where some bit of `out_idle` is 1, or where the length gives a spare slot, or where a slot is forced.
- R5: When `cfg_len` is in 17..20 or 34..40, a held request wins on the first `cyc_start` after it is accepted.
- R6: When `cfg_len` is 16 or 32 and `cfg_prio` is 0, a request waits through any number of packet cycles until an idle port of the required kind appears. Any other length not listed in R5 behaves the same way, whatever `cfg_prio` is.
- R7: When `cfg_len` is 16 or 32 and `cfg_prio` is 1, a request that has missed two `cyc_start` events wins on the third. If no idle port of the required kind exists on that third event, `slot_steal` is 1 together with `mem_en`.
- R8: `mem_en` is 1 for exactly the clock after the winning `cyc_start`. In that clock `mem_we`, `mem_row`, `mem_bank` (0 = master RAM, 1 = slave RAM) and `mem_wdata` carry the captured request. `cpu_done` is 1 for exactly the following clock. In that clock `cpu_rdata` equals `mem_rdata` for a read and is 0 for a write.
- R9: `cpu_busy` is 0 on the clock after `cpu_done`, and a new request is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 6 | Packet-cycle length in bytes |
| cfg_prio | input | 1 | Allows a slot to be forced for lengths 16 and 32 |
| cyc_start | input | 1 | One-clock pulse at the start of each packet cycle |
| in_idle | input | NUM_IN | One bit per packet input, 1 = idle in this cycle |
| out_idle | input | NUM_OUT | One bit per packet output, 1 = idle in this cycle |
| cpu_req | input | 1 | Host request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_row | input | 9 | Row address |
| cpu_bank | input | 1 | RAM select: 0 master, 1 slave |
| cpu_wdata | input | DATA_W | Write data |
| cpu_busy | output | 1 | A request is held |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_done` is 1 |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_row | output | 9 | Memory row |
| mem_bank | output | 1 | RAM select |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one clock after `mem_en` |
| slot_steal | output | 1 | The granted slot was taken from packet traffic |

## Verification
The assertions assume that `cfg_len` and `cfg_prio` do not change while a request is held. They also assume that `cyc_start` pulses are at least four clocks apart, so that a grant and its completion finish before the next packet cycle begins. The bench changes configuration only while `cpu_busy` is 0. It drives `cyc_start` on every fourth clock. It releases the idle vectors only after a chosen number of missed packet cycles, which reaches the forced, stalled and spare-slot paths in turn.

// File: rtl/sma_pkg.sv
package sma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_GRANT = 2'd2,
        ST_DONE  = 2'd3
    } sma_state_e;

    localparam int unsigned ROW_W   = 9;
    localparam int unsigned LEN_W   = 6;
    localparam int unsigned FORCE_N = 2;
endpackage

// File: rtl/sma_len_class.sv
module sma_len_class
    import sma_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    output logic             spare,
    output logic             tight
);
    always_comb begin
        spare = ((len >= LEN_W'(17)) && (len <= LEN_W'(20))) ||
                ((len >= LEN_W'(34)) && (len <= LEN_W'(40)));
        tight = (len == LEN_W'(16)) || (len == LEN_W'(32));
    end
endmodule

// File: rtl/sma_slot_check.sv
module sma_slot_check #(
    parameter int unsigned NUM_IN  = 16,
    parameter int unsigned NUM_OUT = 16
) (
    input  logic               we,
    input  logic [NUM_IN-1:0]  in_idle,
    input  logic [NUM_OUT-1:0] out_idle,
    input  logic               spare,
    input  logic               force_slot,
    output logic               natural,
    output logic               eligible
);
    always_comb begin
        natural  = we ? (|in_idle) : (|out_idle);
        eligible = natural || spare || force_slot;
    end
endmodule

// File: rtl/sma_host_arbiter.sv
module sma_host_arbiter
    import sma_pkg::*;
#(
    parameter int unsigned NUM_IN  = 16,
    parameter int unsigned NUM_OUT = 16,
    parameter int unsigned DATA_W  = 160
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [5:0]         cfg_len,
    input  logic               cfg_prio,
    input  logic               cyc_start,
    input  logic [NUM_IN-1:0]  in_idle,
    input  logic [NUM_OUT-1:0] out_idle,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [8:0]         cpu_row,
    input  logic               cpu_bank,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_busy,
    output logic               cpu_done,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [8:0]         mem_row,
    output logic               mem_bank,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               slot_steal
);
    localparam int unsigned CNT_W = $clog2(FORCE_N + 1);

    sma_state_e            state_q, state_d;
    logic [CNT_W-1:0]      wait_q;
    logic                  we_q, bank_q, steal_q;
    logic [ROW_W-1:0]      row_q;
    logic [DATA_W-1:0]     wdata_q;
    logic                  spare, tight, force_slot, natural, eligible, win;

    sma_len_class u_len (
        .len   (cfg_len),
        .spare (spare),
        .tight (tight)
    );

    assign force_slot = cfg_prio && tight && (wait_q == CNT_W'(FORCE_N));

    sma_slot_check #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_slot (
        .we         (we_q),
        .in_idle    (in_idle),
        .out_idle   (out_idle),
        .spare      (spare),
        .force_slot (force_slot),
        .natural    (natural),
        .eligible   (eligible)
    );

    assign win = (state_q == ST_WAIT) && cyc_start && eligible;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req) state_d = ST_WAIT;
            ST_WAIT:  if (win)     state_d = ST_GRANT;
            ST_GRANT: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // request capture and wait counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q  <= '0;
            we_q    <= 1'b0;
            bank_q  <= 1'b0;
            row_q   <= '0;
            wdata_q <= '0;
            steal_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && cpu_req) begin
                wait_q  <= '0;
                we_q    <= cpu_we;
                bank_q  <= cpu_bank;
                row_q   <= cpu_row;
                wdata_q <= cpu_wdata;
            end
            if (state_q == ST_WAIT && cyc_start) begin
                if (eligible)
                    steal_q <= !(natural || spare);
                else if (wait_q != CNT_W'(FORCE_N))
                    wait_q <= wait_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        cpu_busy   = 1'b1;
        cpu_done   = 1'b0;
        cpu_rdata  = '0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_row    = '0;
        mem_bank   = 1'b0;
        mem_wdata  = '0;
        slot_steal = 1'b0;
        unique case (state_q)
            ST_IDLE: cpu_busy = 1'b0;
            ST_WAIT: ;
            ST_GRANT: begin
                mem_en     = 1'b1;
                mem_we     = we_q;
                mem_row    = row_q;
                mem_bank   = bank_q;
                mem_wdata  = wdata_q;
                slot_steal = steal_q;
            end
            ST_DONE: begin
                cpu_done  = 1'b1;
                cpu_rdata = we_q ? '0 : mem_rdata;
            end
        endcase
    end
endmodule

// File: rtl/sma_host_arbiter_chk.sv
module sma_host_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] cfg_len,
    input logic       cfg_prio,
    input logic       cyc_start,
    input logic       cpu_req,
    input logic       cpu_busy,
    input logic       cpu_done,
    input logic       mem_en,
    input logic       slot_steal
);
    logic       spare_c, tight_c, waiting;
    logic [3:0] seen;

    assign spare_c = ((cfg_len >= 6'd17) && (cfg_len <= 6'd20)) ||
                     ((cfg_len >= 6'd34) && (cfg_len <= 6'd40));
    assign tight_c = (cfg_len == 6'd16) || (cfg_len == 6'd32);
    assign waiting = cpu_busy && !mem_en && !cpu_done;

    always_ff @(posedge clk) begin
        if (!rst_n || !cpu_busy) seen <= '0;
        else if (waiting && cyc_start && seen != 4'hF) seen <= seen + 4'd1;
    end

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_busy && cpu_req) |=> cpu_busy);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |=> cpu_busy);
    // R8
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (!mem_en && cpu_done));
    // R8
    grant_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en) |-> $past(cyc_start));
    // R9
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_busy);
    // R5
    spare_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && cyc_start && spare_c) |=> mem_en);
    // R7
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_prio && tight_c) |-> (seen <= 4'd3));
    // R7
    steal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_steal |-> (mem_en && cfg_prio && tight_c));
endmodule

bind sma_host_arbiter sma_host_arbiter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_len    (cfg_len),
    .cfg_prio   (cfg_prio),
    .cyc_start  (cyc_start),
    .cpu_req    (cpu_req),
    .cpu_busy   (cpu_busy),
    .cpu_done   (cpu_done),
    .mem_en     (mem_en),
    .slot_steal (slot_steal)
);

// File: tb/tb_sma_host_arbiter.sv
`timescale 1ns/1ps
module tb_sma_host_arbiter;
    localparam int DW = 160;
    localparam int NI = 16;
    localparam int NO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    cfg_len = 6'd18;
    logic          cfg_prio = 1'b0;
    logic          cyc_start = 1'b0;
    logic [NI-1:0] in_idle = '0;
    logic [NO-1:0] out_idle = '0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0, cpu_bank = 1'b0;
    logic [8:0]    cpu_row = '0;
    logic [DW-1:0] cpu_wdata = '0, mem_rdata = '0;
    logic          cpu_busy, cpu_done, mem_en, mem_we, mem_bank, slot_steal;
    logic [8:0]    mem_row;
    logic [DW-1:0] cpu_rdata, mem_wdata;

    sma_host_arbiter #(.NUM_IN(NI), .NUM_OUT(NO), .DATA_W(DW)) dut (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int in_after = 1000, out_after = 1000;
    int tick = 0, div = 0;

    // reference model state
    int          m_st = 0, m_cnt = 0, waited = 0, lat = 0;
    bit          m_we, m_bank, m_steal, saw_steal;
    logic [8:0]  m_row;
    logic [DW-1:0] m_wd;

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // stimulus of packet-cycle timing and idle ports
    always @(negedge clk) begin
        tick++;
        mem_rdata <= {5{tick[31:0] ^ 32'h5A5A_0000}};
        div       <= (div + 1) % 4;
        cyc_start <= (div == 2);
        in_idle   <= (waited >= in_after)  ? NI'(16'h0010) : '0;
        out_idle  <= (waited >= out_after) ? NO'(16'h8000) : '0;
    end

    // reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; waited = 0;
        end else begin
            case (m_st)
                0: if (cpu_req) begin
                    m_st = 1; m_cnt = 0; waited = 0;
                    m_we = cpu_we; m_bank = cpu_bank; m_row = cpu_row; m_wd = cpu_wdata;
                end
                1: if (cyc_start) begin
                    bit nat, spr, frc;
                    nat = m_we ? (in_idle != 0) : (out_idle != 0);
                    spr = (cfg_len >= 17 && cfg_len <= 20) || (cfg_len >= 34 && cfg_len <= 40);
                    frc = cfg_prio && (cfg_len == 16 || cfg_len == 32) && m_cnt == 2;
                    if (nat || spr || frc) begin
                        m_st = 2; m_steal = !(nat || spr); lat = waited + 1;
                    end else begin
                        if (m_cnt < 2) m_cnt++;
                        waited++;
                    end
                end
                2: m_st = 3;
                default: m_st = 0;
            endcase
        end
    end

    // per-clock comparison away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R2", "busy", DW'(cpu_busy), DW'(m_st != 0));
            chk(m_we ? "R3" : "R4", "mem_en", DW'(mem_en), DW'(m_st == 2));
            chk("R8", "done", DW'(cpu_done), DW'(m_st == 3));
            chk("R7", "steal", DW'(slot_steal), DW'(m_st == 2 && m_steal));
            if (m_st == 2) begin
                chk("R8", "mem_we", DW'(mem_we), DW'(m_we));
                chk("R8", "mem_row", DW'(mem_row), DW'(m_row));
                chk("R8", "mem_bank", DW'(mem_bank), DW'(m_bank));
                chk("R8", "mem_wdata", mem_wdata, m_wd);
                if (slot_steal) saw_steal = 1;
            end
            if (m_st == 3) chk("R8", "rdata", cpu_rdata, m_we ? '0 : mem_rdata);
        end
    end

    task automatic access(bit we, logic [8:0] row, bit bank, logic [5:0] len, bit prio,
                          int ia, int oa, int exp_lat, bit exp_steal, string req);
        @(negedge clk);
        cfg_len = len; cfg_prio = prio; in_after = ia; out_after = oa; saw_steal = 0;
        cpu_req = 1; cpu_we = we; cpu_row = row; cpu_bank = bank;
        cpu_wdata = {5{23'h0, row}} ^ {DW{we}};
        @(negedge clk);
        cpu_req = 1; cpu_row = ~row; cpu_bank = ~bank; cpu_we = ~we;  // ignored (R2)
        @(negedge clk);
        cpu_req = 0;
        while (!cpu_done) @(negedge clk);
        @(negedge clk);
        chk("R9", "busy after done", DW'(cpu_busy), '0);
        chk(req, "latency", DW'(lat), DW'(exp_lat));
        chk(req, "steal seen", DW'(saw_steal), DW'(exp_steal));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", DW'(cpu_busy), '0);
        chk("R1", "mem_en in reset", DW'(mem_en), '0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1", "done after reset", DW'(cpu_done), '0);
        chk("R1", "steal after reset", DW'(slot_steal), '0);
        access(1, 9'd5,   0, 6'd18, 0, 1000, 1000, 1, 0, "R5");
        access(0, 9'd511, 1, 6'd38, 1, 1000, 1000, 1, 0, "R5");
        access(1, 9'd77,  1, 6'd16, 0, 3,    0,    4, 0, "R3");
        access(0, 9'd300, 0, 6'd32, 0, 0,    2,    3, 0, "R4");
        access(0, 9'd12,  0, 6'd24, 1, 0,    5,    6, 0, "R6");
        access(1, 9'd1,   1, 6'd16, 1, 1000, 1000, 3, 1, "R7");
        access(0, 9'd450, 0, 6'd32, 1, 1000, 1000, 3, 1, "R7");
        access(1, 9'd99,  0, 6'd32, 1, 1,    1000, 2, 0, "R7");
        access(0, 9'd0,   1, 6'd20, 0, 1000, 0,    1, 0, "R8");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule